// File: doc/BRIEF.md
# Programmable Interval Timer Channel

This block is a single 16-bit down-counting timer channel behind a byte-wide register port. A control write selects the counting mode or asks for a snapshot of the count. Data writes load a reload value one byte at a time, and data reads return the count one byte at a time, either live or from a frozen snapshot. Counting advances only on a one-cycle tick enable. That tick is generated outside the block from a timer reference near 1.19318 MHz.

The channel supports three modes: a one-shot that raises its output on expiry, a rate generator that emits a one-tick low pulse every period, and a square wave with a rounded-up high half. Each terminal event produces a one-cycle interrupt pulse. A control word that asks for a feature this channel lacks is refused, and a sticky error flag records the refusal.

Top module: `pit_channel`

## Requirements
- R1: After synchronous reset, the count reads 0x0000, `timer_out`, `tc_irq` and `cfg_err` are 0, and both the read and write byte pointers select the low byte.
- R2: A write with `sel_ctrl`=1 is a control word with these fields. Bits 7:6 equal to 3 is a read-back request and is refused. Otherwise bits 5:4 = 00 is a latch command. Bits 5:4 = 11 is accepted only when bits 3:1 are 0, 2 or 3 and bit 0 (BCD) is 0. Every other control word is refused. A refused word changes nothing except to set `cfg_err`, which stays set until reset.
- R3: A latch command copies the current count into a holding register and leaves mode, reload value and counting unchanged. A latch command that arrives while a held value is still pending is ignored.
- R4: Data reads alternate low byte then high byte. While a latch is pending, the bytes come from the held value, and the latch is released after its high byte is read. Otherwise the bytes come from the live count.
- R5: Data writes alternate low byte then high byte. A low-byte write replaces count bits 7:0 and halts counting. A high-byte write replaces bits 15:8, makes the new count the reload period and starts counting. While neither a tick nor a write occurs, the count does not change.
- R6: Mode 0 (one-shot): starting a count drives `timer_out` low. After N ticks the count reaches 0, `timer_out` rises and stays high, and counting stops with no reload.
- R7: Mode 2 (rate generator): on the tick taken at a count of 1, the counter reloads the period and keeps running. `timer_out` is low for exactly one tick interval per period, namely the interval while the count is 1.
- R8: Mode 3 (square wave): `timer_out` is high while the count exceeds half the period, rounded down, and low otherwise. The high half therefore has ceil(N/2) ticks and the low half floor(N/2). The counter reloads on the tick taken at a count of 1.
- R9: Each terminal event raises `tc_irq` for exactly one clock cycle, in the cycle after the tick edge that caused it. `tc_irq` is never high unless `tick_en` was high on the previous edge.
- R10: A programmed count of 0 acts as 65536 ticks.
- R11: An accepted mode control word stops counting and resets both byte pointers to the low byte. It drives `timer_out` low for mode 0 and high for modes 2 and 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | One-cycle count enable from the reference divider |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe; advances the read byte pointer |
| sel_ctrl | input | 1 | 1 selects the control word, 0 the count data |
| wdata | input | 8 | Write byte |
| rdata | output | 8 | Read byte (combinational from the byte pointer) |
| timer_out | output | 1 | Timer output level |
| tc_irq | output | 1 | Terminal-count interrupt pulse |
| cfg_err | output | 1 | Sticky refused-control-word flag |

## Verification
Four properties are checked every cycle. The error flag is sticky. An interrupt pulse always follows a tick. A one-shot output, once high, never drops without a write. An accepted control word leaves the output at the level its mode dictates. The count is also checked to stay frozen when no tick or write occurs.

Only the bench scenarios can show the rest: byte ordering, latch freezing and release, period lengths and duty in the repeating modes, and the 65536-tick expiry for a zero count. Each of these needs a sequence of writes and ticks, followed by readback of the count.

// File: rtl/pit_pkg.sv
package pit_pkg;

    localparam int BYTE_W = 8;
    localparam int CNT_W  = 2 * BYTE_W;

    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [CNT_W-1:0]  cnt_t;
    typedef logic [CNT_W:0]    cnt_ext_t;

    typedef enum logic [2:0] {
        MODE_ONESHOT = 3'd0,
        MODE_RATE    = 3'd2,
        MODE_SQUARE  = 3'd3
    } mode_e;

    localparam logic [1:0] SEL_READBACK = 2'b11;
    localparam logic [1:0] ACC_LATCH    = 2'b00;
    localparam logic [1:0] ACC_LOHI     = 2'b11;

    typedef struct packed {
        logic  latch;
        logic  prog;
        logic  bad;
        mode_e mode;
    } ctrl_cmd_t;

    // A loaded zero stands for the full 2^CNT_W range.
    function automatic cnt_ext_t eff_count(cnt_t c);
        if (c == '0)
            return {1'b1, {CNT_W{1'b0}}};
        return {1'b0, c};
    endfunction

    // Output level of the repeating modes for a given count and period.
    function automatic logic wave_level(mode_e m, cnt_t c, cnt_t p);
        logic lvl;
        case (m)
            MODE_RATE:   lvl = (c != cnt_t'(1));
            MODE_SQUARE: lvl = (eff_count(c) > (eff_count(p) >> 1));
            default:     lvl = 1'b0;
        endcase
        return lvl;
    endfunction

endpackage

// File: rtl/pit_ctrl_decode.sv
module pit_ctrl_decode
    import pit_pkg::*;
(
    input  byte_t     ctrl_byte,
    output ctrl_cmd_t cmd
);

    logic [1:0] sel_f;
    logic [1:0] acc_f;
    logic [2:0] mode_f;
    logic       bcd_f;
    logic       mode_ok;

    always_comb begin
        sel_f   = ctrl_byte[7:6];
        acc_f   = ctrl_byte[5:4];
        mode_f  = ctrl_byte[3:1];
        bcd_f   = ctrl_byte[0];
        mode_ok = (mode_f == 3'd0) || (mode_f == 3'd2) || (mode_f == 3'd3);

        cmd       = '0;
        cmd.mode  = MODE_ONESHOT;
        if (sel_f == SEL_READBACK) begin
            cmd.bad = 1'b1;
        end else if (acc_f == ACC_LATCH) begin
            cmd.latch = 1'b1;
        end else if (acc_f == ACC_LOHI && mode_ok && !bcd_f) begin
            cmd.prog = 1'b1;
            cmd.mode = mode_e'(mode_f);
        end else begin
            cmd.bad = 1'b1;
        end
    end

endmodule

// File: rtl/pit_byte_port.sv
module pit_byte_port
    import pit_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  rd_stb,
    input  logic  wr_stb,
    input  logic  latch_req,
    input  logic  ptr_clr,
    input  cnt_t  live_cnt,
    output byte_t rd_byte,
    output logic  wr_lo,
    output logic  wr_hi
);

    logic rd_hi_q;
    logic wr_hi_q;
    logic hold_vld_q;
    cnt_t hold_q;
    cnt_t rd_src;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_hi_q    <= 1'b0;
            wr_hi_q    <= 1'b0;
            hold_vld_q <= 1'b0;
            hold_q     <= '0;
        end else begin
            if (latch_req && !hold_vld_q) begin
                hold_q     <= live_cnt;
                hold_vld_q <= 1'b1;
            end
            if (ptr_clr) begin
                rd_hi_q <= 1'b0;
                wr_hi_q <= 1'b0;
            end else begin
                if (rd_stb) begin
                    rd_hi_q <= ~rd_hi_q;
                    if (rd_hi_q && hold_vld_q)
                        hold_vld_q <= 1'b0;
                end
                if (wr_stb)
                    wr_hi_q <= ~wr_hi_q;
            end
        end
    end

    always_comb begin
        rd_src  = hold_vld_q ? hold_q : live_cnt;
        rd_byte = rd_hi_q ? rd_src[CNT_W-1:BYTE_W] : rd_src[BYTE_W-1:0];
        wr_lo   = wr_stb & ~wr_hi_q;
        wr_hi   = wr_stb &  wr_hi_q;
    end

endmodule

// File: rtl/pit_down_counter.sv
module pit_down_counter
    import pit_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  tick,
    input  logic  prog,
    input  mode_e prog_mode,
    input  logic  wr_lo,
    input  logic  wr_hi,
    input  byte_t wdata,
    output cnt_t  cnt,
    output mode_e mode,
    output logic  wave_out,
    output logic  tc_pulse
);

    cnt_t  cnt_q;
    cnt_t  period_q;
    mode_e mode_q;
    logic  run_q;
    logic  out_q;
    logic  tc_q;
    cnt_t  loaded;
    cnt_t  dec;
    logic  at_one;

    always_comb begin
        loaded = {wdata, cnt_q[BYTE_W-1:0]};
        dec    = cnt_q - cnt_t'(1);
        at_one = (cnt_q == cnt_t'(1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q    <= '0;
            period_q <= '0;
            mode_q   <= MODE_ONESHOT;
            run_q    <= 1'b0;
            out_q    <= 1'b0;
            tc_q     <= 1'b0;
        end else begin
            tc_q <= 1'b0;
            if (prog) begin
                mode_q <= prog_mode;
                run_q  <= 1'b0;
                out_q  <= (prog_mode != MODE_ONESHOT);
            end else if (wr_lo) begin
                cnt_q[BYTE_W-1:0] <= wdata;
                run_q             <= 1'b0;
            end else if (wr_hi) begin
                cnt_q    <= loaded;
                period_q <= loaded;
                run_q    <= 1'b1;
                out_q    <= (mode_q == MODE_ONESHOT) ? 1'b0
                                                     : wave_level(mode_q, loaded, loaded);
            end else if (tick && run_q) begin
                if (at_one) begin
                    tc_q <= 1'b1;
                    if (mode_q == MODE_ONESHOT) begin
                        cnt_q <= '0;
                        out_q <= 1'b1;
                        run_q <= 1'b0;
                    end else begin
                        cnt_q <= period_q;
                        out_q <= wave_level(mode_q, period_q, period_q);
                    end
                end else begin
                    cnt_q <= dec;
                    if (mode_q != MODE_ONESHOT)
                        out_q <= wave_level(mode_q, dec, period_q);
                end
            end
        end
    end

    assign cnt      = cnt_q;
    assign mode     = mode_q;
    assign wave_out = out_q;
    assign tc_pulse = tc_q;

endmodule

// File: rtl/pit_channel.sv
module pit_channel
    import pit_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_en,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic             sel_ctrl,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] rdata,
    output logic             timer_out,
    output logic             tc_irq,
    output logic             cfg_err
);

    ctrl_cmd_t cmd;
    logic      ctrl_wr;
    logic      data_wr;
    logic      data_rd;
    logic      latch_req;
    logic      prog;
    logic      wr_lo;
    logic      wr_hi;
    cnt_t      cnt_live;
    mode_e     mode_q;
    logic      err_q;

    assign ctrl_wr   = wr_en & sel_ctrl;
    assign data_wr   = wr_en & ~sel_ctrl;
    assign data_rd   = rd_en & ~sel_ctrl;
    assign latch_req = ctrl_wr & cmd.latch;
    assign prog      = ctrl_wr & cmd.prog;

    pit_ctrl_decode u_decode (
        .ctrl_byte (wdata),
        .cmd       (cmd)
    );

    pit_byte_port u_port (
        .clk       (clk),
        .rst       (rst),
        .rd_stb    (data_rd),
        .wr_stb    (data_wr),
        .latch_req (latch_req),
        .ptr_clr   (prog),
        .live_cnt  (cnt_live),
        .rd_byte   (rdata),
        .wr_lo     (wr_lo),
        .wr_hi     (wr_hi)
    );

    pit_down_counter u_counter (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick_en),
        .prog      (prog),
        .prog_mode (cmd.mode),
        .wr_lo     (wr_lo),
        .wr_hi     (wr_hi),
        .wdata     (wdata),
        .cnt       (cnt_live),
        .mode      (mode_q),
        .wave_out  (timer_out),
        .tc_pulse  (tc_irq)
    );

    always_ff @(posedge clk) begin
        if (rst)
            err_q <= 1'b0;
        else if (ctrl_wr && cmd.bad)
            err_q <= 1'b1;
    end

    assign cfg_err = err_q;

endmodule

// File: rtl/pit_channel_checker.sv
module pit_channel_checker
    import pit_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       tick_en,
    input logic       wr_en,
    input logic       sel_ctrl,
    input logic [7:0] wdata,
    input logic       timer_out,
    input logic       tc_irq,
    input logic       cfg_err,
    input mode_e      mode_q,
    input cnt_t       cnt_live
);

    logic good_prog;
    assign good_prog = wr_en && sel_ctrl && (wdata[7:6] != 2'b11) &&
                       (wdata[5:4] == 2'b11) && !wdata[0] &&
                       (wdata[3:1] == 3'd0 || wdata[3:1] == 3'd2 || wdata[3:1] == 3'd3);

    assert_err_sticky_R2: assert property (@(posedge clk) disable iff (rst)
        cfg_err |=> cfg_err);

    assert_hold_count_R5: assert property (@(posedge clk) disable iff (rst)
        (!tick_en && !wr_en) |=> $stable(cnt_live));

    assert_oneshot_stays_R6: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_ONESHOT && timer_out && !wr_en) |=> timer_out);

    assert_irq_after_tick_R9: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && tc_irq) |-> $past(tick_en));

    assert_prog_level_R11: assert property (@(posedge clk) disable iff (rst)
        good_prog |=> (timer_out == ($past(wdata[3:1]) != 3'd0)));

endmodule

bind pit_channel pit_channel_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .tick_en   (tick_en),
    .wr_en     (wr_en),
    .sel_ctrl  (sel_ctrl),
    .wdata     (wdata),
    .timer_out (timer_out),
    .tc_irq    (tc_irq),
    .cfg_err   (cfg_err),
    .mode_q    (mode_q),
    .cnt_live  (cnt_live)
);

// File: tb/pit_channel_bench.sv
module pit_channel_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_en = 1'b0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic       sel_ctrl = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       timer_out;
    logic       tc_irq;
    logic       cfg_err;

    int checks = 0;
    int errors = 0;
    int lows   = 0;
    int irqs   = 0;
    logic [7:0] rb_lo;
    logic [7:0] rb_hi;

    always #2 clk = ~clk;

    pit_channel u_pit_channel (
        .clk       (clk),
        .rst       (rst),
        .tick_en   (tick_en),
        .wr_en     (wr_en),
        .rd_en     (rd_en),
        .sel_ctrl  (sel_ctrl),
        .wdata     (wdata),
        .rdata     (rdata),
        .timer_out (timer_out),
        .tc_irq    (tc_irq),
        .cfg_err   (cfg_err)
    );

    // {control byte, expected cfg_err} for R2
    localparam logic [8:0] CTRL_VEC [11] = '{
        {8'h34, 1'b0}, {8'h30, 1'b0}, {8'h36, 1'b0}, {8'h32, 1'b1},
        {8'h38, 1'b1}, {8'h35, 1'b1}, {8'h10, 1'b1}, {8'h20, 1'b1},
        {8'hF4, 1'b1}, {8'h00, 1'b0}, {8'h3C, 1'b1}
    };

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wr(input logic ctl, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; sel_ctrl = ctl; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; sel_ctrl = 1'b0;
    endtask

    task automatic rd(output logic [7:0] d);
        @(negedge clk);
        rd_en = 1'b1; sel_ctrl = 1'b0;
        #1 d = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic rd16(output logic [7:0] lo, output logic [7:0] hi);
        rd(lo);
        rd(hi);
    endtask

    task automatic ticks(input int n);
        lows = 0;
        irqs = 0;
        @(negedge clk);
        tick_en = 1'b1;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            lows += (timer_out == 1'b0) ? 1 : 0;
            irqs += tc_irq ? 1 : 0;
        end
        tick_en = 1'b0;
    endtask

    initial begin
        #(4 * 190000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // R1: reset state
        do_reset();
        check("R1 out", timer_out, 0);
        check("R1 irq", tc_irq, 0);
        check("R1 err", cfg_err, 0);
        rd16(rb_lo, rb_hi);
        check("R1 count", {rb_hi, rb_lo}, 16'h0000);

        // R2: control word table
        for (int v = 0; v < 11; v++) begin
            do_reset();
            wr(1'b1, CTRL_VEC[v][8:1]);
            check("R2 decode", cfg_err, CTRL_VEC[v][0]);
        end

        // R2: sticky, and a refused word changes nothing else
        do_reset();
        wr(1'b1, 8'h34);
        wr(1'b1, 8'h32);
        check("R2 refused keeps out", timer_out, 1);
        wr(1'b1, 8'h30);
        check("R2 sticky", cfg_err, 1);
        check("R11 mode0 low", timer_out, 0);
        do_reset();
        check("R1 err cleared", cfg_err, 0);

        // R6: one-shot with N=3
        wr(1'b1, 8'h30);
        wr(1'b0, 8'h03);
        wr(1'b0, 8'h00);
        check("R6 start low", timer_out, 0);
        ticks(2);
        check("R6 not yet", timer_out, 0);
        check("R9 no early irq", irqs, 0);
        ticks(1);
        check("R6 expired", timer_out, 1);
        check("R9 one irq", irqs, 1);
        @(negedge clk);
        check("R9 single cycle", tc_irq, 0);
        ticks(5);
        check("R6 stays high", timer_out, 1);
        check("R6 no reload irq", irqs, 0);
        rd16(rb_lo, rb_hi);
        check("R6 stopped at zero", {rb_hi, rb_lo}, 0);

        // R7: rate generator N=4
        do_reset();
        wr(1'b1, 8'h34);
        check("R11 mode2 high", timer_out, 1);
        wr(1'b0, 8'h04);
        wr(1'b0, 8'h00);
        ticks(2);
        check("R7 high before one", timer_out, 1);
        ticks(1);
        check("R7 low at one", timer_out, 0);
        ticks(9);
        check("R7 low ticks", lows, 2);
        check("R7 irqs", irqs, 3);
        rd16(rb_lo, rb_hi);
        check("R7 reloaded count", {rb_hi, rb_lo}, 16'h0004);

        // R8: square wave odd and even periods
        wr(1'b1, 8'h36);
        wr(1'b0, 8'h05);
        wr(1'b0, 8'h00);
        ticks(10);
        check("R8 odd low ticks", lows, 4);
        check("R8 odd irqs", irqs, 2);
        check("R8 odd end high", timer_out, 1);
        wr(1'b1, 8'h36);
        wr(1'b0, 8'h04);
        wr(1'b0, 8'h00);
        ticks(8);
        check("R8 even low ticks", lows, 4);
        check("R8 even irqs", irqs, 2);

        // R3/R4: latch behaviour
        do_reset();
        wr(1'b1, 8'h34);
        wr(1'b0, 8'h34);
        wr(1'b0, 8'h12);
        ticks(3);
        wr(1'b1, 8'h00);
        ticks(2);
        wr(1'b1, 8'h00);
        check("R3 latch accepted", cfg_err, 0);
        rd(rb_lo);
        ticks(1);
        rd(rb_hi);
        check("R3 held value", {rb_hi, rb_lo}, 16'h1231);
        rd16(rb_lo, rb_hi);
        check("R4 live after release", {rb_hi, rb_lo}, 16'h122E);
        wr(1'b1, 8'h00);
        ticks(1);
        rd16(rb_lo, rb_hi);
        check("R3 relatch", {rb_hi, rb_lo}, 16'h122E);

        // R5: low byte halts, high byte starts
        wr(1'b0, 8'h50);
        ticks(3);
        rd16(rb_lo, rb_hi);
        check("R5 halted after low", {rb_hi, rb_lo}, 16'h1250);
        wr(1'b0, 8'h00);
        ticks(16);
        rd16(rb_lo, rb_hi);
        check("R5 counting after high", {rb_hi, rb_lo}, 16'h0040);

        // R11: control word resets pointers and stops counting
        rd(rb_lo);
        wr(1'b1, 8'h34);
        ticks(3);
        rd(rb_lo);
        check("R11 read ptr low", rb_lo, 8'h40);
        rd(rb_hi);
        check("R11 stopped", rb_hi, 8'h00);
        wr(1'b0, 8'h07);
        wr(1'b1, 8'h34);
        wr(1'b0, 8'h03);
        wr(1'b0, 8'h00);
        ticks(2);
        check("R11 write ptr low", timer_out, 0);

        // R10: zero count acts as 65536
        wr(1'b1, 8'h30);
        wr(1'b0, 8'h00);
        wr(1'b0, 8'h00);
        ticks(65535);
        check("R10 not expired", timer_out, 0);
        ticks(1);
        check("R10 expired", timer_out, 1);
        check("R10 irq", irqs, 1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule